// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor-side word port and a main-memory port that moves whole lines. It stores 128 lines of 16 words, addressed by a 16-bit word address. Each memory line can live in exactly one cache slot, chosen by the line number modulo 128. Every access reads the tag kept for that slot. If the tag matches and the slot holds a line, the access completes in place. If not, the block allocates the slot, for reads and for writes alike.

On a miss, a slot whose contents differ from memory is first streamed out to memory in 16 word beats. The new line is then streamed in the same way. After that the pending read or write completes against the freshly filled slot. Writes never go straight to memory. A write only marks its slot as modified, and that mark is what later decides whether the slot is written back before it is reused.

The processor sees a single request strobe, a busy level and a one-cycle completion pulse. Both memory channels use a valid/ready handshake for each beat.

Top module: `dmc_cache`

## Requirements
- R1: The address splits as follows: bits [3:0] pick the word in the line, bits [10:4] pick the slot and bits [15:11] are the tag. The line number reported to memory is bits [15:4]. Address 0x357A therefore uses slot 87 and fetches memory line 855 (0x357).
- R2: After reset no slot holds a line, so the first access to any address misses. Directly after reset, `cpu_busy`, `cpu_done`, `wb_valid` and `fill_ready` are all low.
- R3: A read or write that hits raises `cpu_done` in the cycle after the request is accepted. It moves no beat on either memory channel. A read hit returns the stored word on `cpu_rdata`.
- R4: A request is accepted when `cpu_req` is high while `cpu_busy` is low. On a read miss the block takes 16 fill beats for the requested line and then raises `cpu_done` with the requested word. `cpu_busy` stays high from the cycle after acceptance until the cycle in which `cpu_done` rises, where it falls.
- R5: A write hit stores `cpu_wdata` into the addressed word, and later reads of that word return it. The slot becomes modified.
- R6: A write miss first fills the line from memory and then writes the word into it. Later reads return the written word, while the other words of the line keep their filled values. The slot becomes modified.
- R7: When a miss replaces a modified slot, the block sends all 16 words of the old line to memory before any fill beat. The beats carry word numbers 0 to 15 in order and the old line number, which is the old tag followed by the slot number.
- R8: When a miss replaces a slot that is empty or unmodified, no write-back beat occurs and only the 16-beat fill takes place.
- R9: A beat on either memory channel counts only in a cycle where both valid and ready are high. While the cache is waiting on a stalled beat, the line number, word number and data it drives stay stable. Write-back and fill never run in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, accepted when not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with cpu_done on reads |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | High while a miss is in progress |
| wb_valid | output | 1 | Write-back beat available |
| wb_ready | input | 1 | Memory accepts a write-back beat |
| wb_line | output | 12 | Line number being written back |
| wb_beat | output | 4 | Word number within the written-back line |
| wb_data | output | 16 | Write-back word |
| fill_ready | output | 1 | Cache is taking fill beats for fill_line |
| fill_valid | input | 1 | Fill beat present |
| fill_line | output | 12 | Line number being fetched |
| fill_data | input | 16 | Fill word, in word order 0 to 15 |

## Verification
A stale modified flag shows up as an extra or missing 16-beat write-back at the next conflict miss on that slot. A corrupt tag or fill-valid bit shows up within one access, as a hit that should have missed or a fill of the wrong line number. Data mixed up between beats or slots appears as a wrong word on `cpu_rdata` at the next read of that address, or at the first read after the line has gone through memory and back. The bench therefore keeps a reference copy of the tags, the flags and the most recent value of every written word, and compares the beat counts, line numbers and data of every access against it.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_FILL = 2'd2,
      ST_DONE = 2'd3
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 128,
   parameter int TAG_W = 5,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output logic             rd_dirty,
   input  logic             fill_set,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx
);
   logic [TAG_W-1:0] tags [LINES];
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            dirty_q[g] <= 1'b0;
         end else if (fill_set && fill_idx == IDX_W'(g)) begin
            valid_q[g] <= 1'b1;
            dirty_q[g] <= 1'b0;
         end else if (mark_en && mark_idx == IDX_W'(g)) begin
            dirty_q[g] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_set) tags[fill_idx] <= fill_tag;
   end

   assign rd_tag   = tags[rd_idx];
   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int DEPTH  = 2048,
   parameter int DATA_W = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dmc_miss_fsm.sv
module dmc_miss_fsm
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 7,
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int DA_W    = IDX_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_done,
   output logic               cpu_busy,
   output logic [IDX_W-1:0]   ts_idx,
   input  logic [TAG_W-1:0]   ts_tag,
   input  logic               ts_valid,
   input  logic               ts_dirty,
   output logic               ts_fill_set,
   output logic [TAG_W-1:0]   ts_fill_tag,
   output logic               ts_mark,
   output logic               da_we,
   output logic [DA_W-1:0]    da_waddr,
   output logic [DATA_W-1:0]  da_wdata,
   output logic [DA_W-1:0]    da_raddr_a,
   input  logic [DATA_W-1:0]  da_rdata_a,
   output logic [DA_W-1:0]    da_raddr_b,
   input  logic [DATA_W-1:0]  da_rdata_b,
   output logic               wb_valid,
   input  logic               wb_ready,
   output logic [LADDR_W-1:0] wb_line,
   output logic [OFF_W-1:0]   wb_beat,
   output logic [DATA_W-1:0]  wb_data,
   output logic               fill_ready,
   input  logic               fill_valid,
   output logic [LADDR_W-1:0] fill_line,
   input  logic [DATA_W-1:0]  fill_data
);
   localparam logic [OFF_W-1:0] LAST_BEAT = '1;

   dmc_state_e        state_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic              req_we_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic [OFF_W-1:0]  beat_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;

   logic [ADDR_W-1:0] look_addr;
   logic [OFF_W-1:0]  l_off;
   logic [IDX_W-1:0]  l_idx;
   logic [TAG_W-1:0]  l_tag;
   logic              hit;
   logic              accept;

   assign look_addr = (state_q == ST_IDLE) ? cpu_addr : req_addr_q;
   assign l_off     = look_addr[OFF_W-1:0];
   assign l_idx     = look_addr[OFF_W +: IDX_W];
   assign l_tag     = look_addr[ADDR_W-1 -: TAG_W];
   assign hit       = ts_valid && (ts_tag == l_tag);
   assign accept    = (state_q == ST_IDLE) && cpu_req;

   assign ts_idx      = l_idx;
   assign ts_fill_tag = l_tag;
   assign da_raddr_a  = {l_idx, l_off};
   assign da_raddr_b  = {l_idx, beat_q};

   assign wb_valid   = (state_q == ST_WB);
   assign wb_line    = {ts_tag, l_idx};
   assign wb_beat    = beat_q;
   assign wb_data    = da_rdata_b;
   assign fill_ready = (state_q == ST_FILL);
   assign fill_line  = {l_tag, l_idx};

   assign cpu_busy  = (state_q != ST_IDLE);
   assign cpu_done  = done_q;
   assign cpu_rdata = rdata_q;

   always_comb begin
      da_we       = 1'b0;
      da_waddr    = {l_idx, l_off};
      da_wdata    = req_wdata_q;
      ts_fill_set = 1'b0;
      ts_mark     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && hit && cpu_we) begin
               da_we    = 1'b1;
               da_wdata = cpu_wdata;
               ts_mark  = 1'b1;
            end
         end
         ST_FILL: begin
            if (fill_valid) begin
               da_we    = 1'b1;
               da_waddr = {l_idx, beat_q};
               da_wdata = fill_data;
               ts_fill_set = (beat_q == LAST_BEAT);
            end
         end
         ST_DONE: begin
            if (req_we_q) begin
               da_we   = 1'b1;
               ts_mark = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_addr_q  <= '0;
         req_we_q    <= 1'b0;
         req_wdata_q <= '0;
         beat_q      <= '0;
         rdata_q     <= '0;
         done_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  req_addr_q  <= cpu_addr;
                  req_we_q    <= cpu_we;
                  req_wdata_q <= cpu_wdata;
                  beat_q      <= '0;
                  if (hit) begin
                     done_q <= 1'b1;
                     if (!cpu_we) rdata_q <= da_rdata_a;
                  end else if (ts_valid && ts_dirty) begin
                     state_q <= ST_WB;
                  end else begin
                     state_q <= ST_FILL;
                  end
               end
            end
            ST_WB: begin
               if (wb_ready) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (fill_valid) begin
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) state_q <= ST_DONE;
               end
            end
            ST_DONE: begin
               done_q  <= 1'b1;
               if (!req_we_q) rdata_q <= da_rdata_a;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int LINES      = 128,
   parameter int LINE_WORDS = 16,
   localparam int OFF_W   = $clog2(LINE_WORDS),
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
   localparam int LADDR_W = ADDR_W - OFF_W,
   localparam int DEPTH   = LINES * LINE_WORDS,
   localparam int DA_W    = IDX_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_done,
   output logic               cpu_busy,
   output logic               wb_valid,
   input  logic               wb_ready,
   output logic [LADDR_W-1:0] wb_line,
   output logic [OFF_W-1:0]   wb_beat,
   output logic [DATA_W-1:0]  wb_data,
   output logic               fill_ready,
   input  logic               fill_valid,
   output logic [LADDR_W-1:0] fill_line,
   input  logic [DATA_W-1:0]  fill_data
);
   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("dmc_cache: LINES must be a power of two of at least 2");
   end
   if ((LINE_WORDS & (LINE_WORDS - 1)) != 0 || LINE_WORDS < 2) begin : g_bad_words
      $error("dmc_cache: LINE_WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dmc_cache: address too narrow for the chosen geometry");
   end

   logic [IDX_W-1:0]  ts_idx;
   logic [TAG_W-1:0]  ts_tag;
   logic              ts_valid;
   logic              ts_dirty;
   logic              ts_fill_set;
   logic [TAG_W-1:0]  ts_fill_tag;
   logic              ts_mark;
   logic              da_we;
   logic [DA_W-1:0]   da_waddr;
   logic [DATA_W-1:0] da_wdata;
   logic [DA_W-1:0]   da_raddr_a;
   logic [DATA_W-1:0] da_rdata_a;
   logic [DA_W-1:0]   da_raddr_b;
   logic [DATA_W-1:0] da_rdata_b;

   dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (ts_idx),
      .rd_tag   (ts_tag),
      .rd_valid (ts_valid),
      .rd_dirty (ts_dirty),
      .fill_set (ts_fill_set),
      .fill_idx (ts_idx),
      .fill_tag (ts_fill_tag),
      .mark_en  (ts_mark),
      .mark_idx (ts_idx)
   );

   dmc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .we      (da_we),
      .waddr   (da_waddr),
      .wdata   (da_wdata),
      .raddr_a (da_raddr_a),
      .rdata_a (da_rdata_a),
      .raddr_b (da_raddr_b),
      .rdata_b (da_rdata_b)
   );

   dmc_miss_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .IDX_W  (IDX_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .cpu_we      (cpu_we),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .cpu_rdata   (cpu_rdata),
      .cpu_done    (cpu_done),
      .cpu_busy    (cpu_busy),
      .ts_idx      (ts_idx),
      .ts_tag      (ts_tag),
      .ts_valid    (ts_valid),
      .ts_dirty    (ts_dirty),
      .ts_fill_set (ts_fill_set),
      .ts_fill_tag (ts_fill_tag),
      .ts_mark     (ts_mark),
      .da_we       (da_we),
      .da_waddr    (da_waddr),
      .da_wdata    (da_wdata),
      .da_raddr_a  (da_raddr_a),
      .da_rdata_a  (da_rdata_a),
      .da_raddr_b  (da_raddr_b),
      .da_rdata_b  (da_rdata_b),
      .wb_valid    (wb_valid),
      .wb_ready    (wb_ready),
      .wb_line     (wb_line),
      .wb_beat     (wb_beat),
      .wb_data     (wb_data),
      .fill_ready  (fill_ready),
      .fill_valid  (fill_valid),
      .fill_line   (fill_line),
      .fill_data   (fill_data)
   );
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
   parameter int LADDR_W = 12,
   parameter int OFF_W   = 4,
   parameter int DATA_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic               cpu_busy,
   input logic               cpu_done,
   input logic               wb_valid,
   input logic               wb_ready,
   input logic [LADDR_W-1:0] wb_line,
   input logic [OFF_W-1:0]   wb_beat,
   input logic [DATA_W-1:0]  wb_data,
   input logic               fill_ready,
   input logic               fill_valid,
   input logic [LADDR_W-1:0] fill_line
);
   // R3: an accepted request either completes next cycle or holds busy
   p_accept_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_busy) |=> (cpu_done || cpu_busy));

   // R3: no memory traffic while idle
   p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> (!wb_valid && !fill_ready));

   // R4: completion pulse coincides with busy released
   p_done_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);

   // R7: last write-back beat hands over to the fill
   p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_ready && wb_beat == '1) |=> fill_ready);

   // R9: stalled write-back beat holds its contents
   p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=>
         (wb_valid && $stable(wb_line) && $stable(wb_beat) && $stable(wb_data)));

   // R9: stalled fill keeps requesting the same line
   p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ready && !fill_valid) |=> (fill_ready && $stable(fill_line)));

   // R9: the two memory channels never overlap
   p_one_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && fill_ready));
endmodule

bind dmc_cache dmc_cache_chk #(
   .LADDR_W (LADDR_W),
   .OFF_W   (OFF_W),
   .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_done;
   logic        cpu_busy;
   logic        wb_valid;
   logic        wb_ready = 1'b0;
   logic [11:0] wb_line;
   logic [3:0]  wb_beat;
   logic [15:0] wb_data;
   logic        fill_ready;
   logic        fill_valid = 1'b0;
   logic [11:0] fill_line;
   logic [15:0] fill_data = '0;

   always #10 clk = ~clk;

   dmc_cache dut (.*);

   typedef struct {
      bit          is_rd;
      logic [15:0] exp;
      int          n_wb;
      int          n_fill;
      int          wline;
      int          fline;
      string       lbl;
   } item_t;

   item_t       q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] backing [int];
   logic [15:0] truth [int];
   logic [4:0]  rtag [128];
   bit          rvld [128];
   bit          rdty [128];
   int          wb_cnt = 0;
   int          fill_cnt = 0;
   int          stall = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic logic [15:0] init_val(int a);
      return 16'(a) ^ 16'hA5C3;
   endfunction
   function automatic logic [15:0] mem_get(int a);
      return backing.exists(a) ? backing[a] : init_val(a);
   endfunction
   function automatic logic [15:0] truth_get(int a);
      return truth.exists(a) ? truth[a] : init_val(a);
   endfunction

   task automatic chk(bit ok, string lbl, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
      end
   endtask

   // memory model and scoreboard monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         stall = stall + 1;
         wb_ready = (stall % 3) != 0;
         fill_valid = fill_ready && ((stall % 4) != 1);
         if (wb_valid && wb_ready) begin
            chk(wb_beat == 4'(wb_cnt), "R9 wb beat order", int'(wb_beat), wb_cnt);
            if (q.size() > 0)
               chk(int'(wb_line) == q[0].wline, "R7 wb line", int'(wb_line), q[0].wline);
            chk(wb_data == truth_get(int'(wb_line) * 16 + int'(wb_beat)),
                "R7 wb data", int'(wb_data), int'(truth_get(int'(wb_line) * 16 + int'(wb_beat))));
            backing[int'(wb_line) * 16 + int'(wb_beat)] = wb_data;
            wb_cnt++;
         end
         if (fill_ready) begin
            chk(wb_cnt == 0 || wb_cnt == 16, "R7 wb before fill", wb_cnt, 16);
            fill_data = mem_get(int'(fill_line) * 16 + fill_cnt);
            if (fill_valid) fill_cnt++;
         end
         if (cpu_done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R4 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               chk(wb_cnt == it.n_wb, {it.lbl, " wb beats R8"}, wb_cnt, it.n_wb);
               chk(fill_cnt == it.n_fill, {it.lbl, " fill beats R9"}, fill_cnt, it.n_fill);
               if (it.is_rd)
                  chk(cpu_rdata == it.exp, {it.lbl, " rdata"}, int'(cpu_rdata), int'(it.exp));
            end
            wb_cnt = 0;
            fill_cnt = 0;
         end
      end
   end

   task automatic access(bit we, logic [15:0] addr, logic [15:0] wd, string lbl);
      item_t it;
      int idx, tg, lat;
      bit hit;
      idx = int'(addr[10:4]);
      tg  = int'(addr[15:11]);
      hit = rvld[idx] && (int'(rtag[idx]) == tg);
      it.is_rd = !we;
      it.n_wb = 0;
      it.n_fill = 0;
      it.wline = 0;
      it.fline = int'(addr[15:4]);
      it.lbl = lbl;
      if (!hit) begin
         if (rvld[idx] && rdty[idx]) begin
            it.n_wb = 16;
            it.wline = int'(rtag[idx]) * 128 + idx;
         end
         it.n_fill = 16;
         rvld[idx] = 1'b1;
         rtag[idx] = 5'(tg);
         rdty[idx] = 1'b0;
      end
      if (we) begin
         rdty[idx] = 1'b1;
         truth[int'(addr)] = wd;
      end
      it.exp = truth_get(int'(addr));
      q.push_back(it);
      @(negedge clk);
      cpu_req = 1'b1;
      cpu_we = we;
      cpu_addr = addr;
      cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      if (!hit && fill_ready)
         chk(int'(fill_line) == it.fline, "R1 fill line", int'(fill_line), it.fline);
      lat = 1;
      while (!cpu_done && lat < 1000) begin
         if (!hit && fill_ready)
            chk(int'(fill_line) == it.fline, "R1 fill line", int'(fill_line), it.fline);
         @(negedge clk);
         lat++;
      end
      if (hit) chk(lat == 1, "R3 hit latency", lat, 1);
      else     chk(lat >= 18, "R4 miss latency", lat, 18);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 128; i++) begin
         rvld[i] = 1'b0;
         rdty[i] = 1'b0;
         rtag[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cpu_busy && !cpu_done && !wb_valid && !fill_ready, "R2 reset outputs",
          {cpu_busy, cpu_done, wb_valid, fill_ready}, 0);

      access(1'b0, 16'h357A, '0, "R2 cold miss R1");
      access(1'b0, 16'h3575, '0, "R3 read hit");
      access(1'b1, 16'h357A, 16'h1234, "R5 write hit");
      access(1'b0, 16'h357A, '0, "R5 read back");
      access(1'b0, 16'h4570, '0, "R7 dirty evict");
      access(1'b0, 16'h357A, '0, "R8 clean evict");
      access(1'b1, 16'h0123, 16'hBEEF, "R6 write miss");
      access(1'b0, 16'h0123, '0, "R6 written word");
      access(1'b0, 16'h0125, '0, "R6 filled word");
      access(1'b0, 16'h8123, '0, "R7 evict write-miss line");
      access(1'b0, 16'h0123, '0, "R7 word via memory");

      for (int n = 0; n < 250; n++) begin
         logic [15:0] a;
         int sel;
         seed = seed * 32'd1103515245 + 32'd12345;
         sel = int'(seed[20:19]);
         a[15:11] = {3'b000, seed[25:24]} ^ 5'(sel);
         a[10:4]  = (sel == 0) ? 7'd87 : (sel == 1) ? 7'd5 : (sel == 2) ? 7'd100 : 7'd18;
         a[3:0]   = seed[29:26];
         access(seed[31], a, seed[15:0], "R6 random mix R5");
      end

      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R4 queue drained", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule